// File: doc/BRIEF.md
# Double-Edge Burst Data Sender (device to host)

This block is the device-side sequencer for a source-synchronous 16-bit burst link in the device-to-host direction. When its local word source has data, it raises a request line and waits for the host's acknowledge. It then places words on the data bus and toggles a strobe. Every strobe transition, rising or falling, hands over one word. The host can throttle the flow with its ready line and can end the burst with a stop line. The device ends the burst by itself when its source runs dry. Every burst closes with a 16-bit CRC word on the data bus, which stays there until the host withdraws its acknowledge.

All protocol intervals are counted in clock cycles. They come from a table indexed by a 3-bit transfer-mode input, and the table is computed from the clock period parameter. The mode is latched when the request is raised, so a change on the mode input during a burst has no effect on it.

Top module: `udma_din_sender`

## Requirements
- R1: After reset and whenever the data bus is not driven, the request line is low, the strobe is high, the bus-drive enable is low and the take pulse is low.
- R2: The request rises while idle when the source offers a word. The bus is not driven and the strobe does not move before the active-low acknowledge is seen. The first strobe transition follows the acknowledge by no more than the mode's first-strobe limit (230, 200, 170, 130, 120, 90 ns for modes 0 to 5).
- R3: Each strobe transition, either polarity, delivers exactly one word, in source order. A word is taken from the source only while the take pulse is high, in the cycle before it appears on the bus.
- R4: Successive strobe transitions are at least 112, 73, 54, 39, 25 or 16.8 ns apart, and transitions of equal polarity are at least 230, 153, 115, 86, 57 or 38 ns apart, for modes 0 to 5.
- R5: A word is on the bus for at least 70, 48, 31, 20, 6.7 or 4.8 ns before its strobe transition (modes 0 to 5). The bus holds it for at least 6.2 ns after the transition (4.8 ns in mode 5).
- R6: While the host ready line (active low) is high, no strobe transition occurs later than 75, 70, 60, 60, 60 or 50 ns (modes 0 to 5) after it went high. Transfer resumes when it returns low.
- R7: When the host raises stop during the transfer, the request drops on the next clock and no further word is strobed.
- R8: When the source has no word, the device ends the burst by dropping the request, no sooner than 50 ns after its last strobe transition. It then waits for the host's stop.
- R9: At the end of a burst the strobe returns high and the bus carries the CRC of all strobed words, and this return transition delivers no word. The CRC uses polynomial 0x1021 with seed 0x4ABA and takes word bits 15 down to 0, most significant first. The CRC is held until the acknowledge goes high, after which the bus is released and the block is idle.
- R10: Mode values 6 and 7 behave as mode 5. A change on the mode input after the request has risen does not alter that burst's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | Transfer mode select (0 to 5; larger values act as 5) |
| word_valid_i | input | 1 | Source has a word ready |
| word_i | input | 16 | Source word |
| word_take_o | output | 1 | Source word is taken at the next clock edge |
| req_o | output | 1 | Burst request to the host |
| ack_n_i | input | 1 | Host acknowledge, active low |
| stop_i | input | 1 | Host stop request |
| host_rdy_n_i | input | 1 | Host ready, active low; high pauses the strobe |
| strobe_o | output | 1 | Data strobe, both edges carry data |
| data_o | output | 16 | Data bus value |
| data_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions take the host lines as synchronous to the block clock and free of glitches. They also assume that the host raises stop only during a transfer or after the device has dropped its request, and that it withdraws the acknowledge only while the CRC is on the bus. The bench host model changes every input a nanosecond after a falling clock edge and acknowledges only after the request is seen. It raises stop either at a chosen word count or in answer to the request dropping, and releases the acknowledge once the CRC has been read. Source words are distinct from their neighbours and nonzero, so each bus update can be seen at the ports.

// File: rtl/udma_pkg.sv
package udma_pkg;

    localparam int TW = 8;
    localparam int TMAX = (1 << TW) - 1;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_ACK, S_DRIVE, S_WSTOP, S_END, S_CRC
    } state_e;

    typedef struct packed {
        logic [TW-1:0] cyc;
        logic [TW-1:0] cyc2;
        logic [TW-1:0] dvs;
        logic [TW-1:0] dvh;
        logic [TW-1:0] ss;
        logic [TW-1:0] ack;
    } tim_t;

    // tenths of a nanosecond to whole clock cycles, rounded up, at least one
    function automatic logic [TW-1:0] to_cycles(input int tenth_ns, input int clk_ps);
        int v;
        v = (tenth_ns * 100 + clk_ps - 1) / clk_ps;
        if (v < 1) v = 1;
        if (v > TMAX) v = TMAX;
        return v[TW-1:0];
    endfunction

    function automatic tim_t mode_timing(input logic [2:0] mode, input int clk_ps);
        tim_t t;
        int c, c2, vs, vh;
        case (mode)
            3'd0:    begin c = 1120; c2 = 2300; vs = 700; vh = 62; end
            3'd1:    begin c = 730;  c2 = 1530; vs = 480; vh = 62; end
            3'd2:    begin c = 540;  c2 = 1150; vs = 310; vh = 62; end
            3'd3:    begin c = 390;  c2 = 860;  vs = 200; vh = 62; end
            3'd4:    begin c = 250;  c2 = 570;  vs = 67;  vh = 62; end
            default: begin c = 168;  c2 = 380;  vs = 48;  vh = 48; end
        endcase
        t.cyc  = to_cycles(c, clk_ps);
        t.cyc2 = to_cycles(c2, clk_ps);
        t.dvs  = to_cycles(vs, clk_ps);
        t.dvh  = to_cycles(vh, clk_ps);
        t.ss   = to_cycles(500, clk_ps);
        t.ack  = to_cycles(200, clk_ps);
        return t;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] crc, input logic [15:0] w);
        logic [15:0] r;
        r = crc;
        for (int i = 15; i >= 0; i--) begin
            if (r[15] ^ w[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

endpackage

// File: rtl/udma_mode_timing.sv
module udma_mode_timing
    import udma_pkg::*;
#(
    parameter int CLK_PS = 20000
) (
    input  logic [2:0] mode_i,
    output tim_t       tim_o
);
    always_comb begin
        tim_o = mode_timing(mode_i, CLK_PS);
    end
endmodule

// File: rtl/udma_sat_counter.sv
module udma_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         fill_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CMAX = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (clr_i)             cnt_d = '0;
        else if (fill_i)       cnt_d = CMAX;
        else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= CMAX;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/udma_crc16.sv
module udma_crc16
    import udma_pkg::*;
#(
    parameter logic [15:0] SEED = 16'h4ABA
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init_i,
    input  logic        upd_i,
    input  logic [15:0] word_i,
    output logic [15:0] crc_o
);
    logic [15:0] crc_d, crc_q;

    always_comb begin
        if (init_i)     crc_d = SEED;
        else if (upd_i) crc_d = crc_step(crc_q, word_i);
        else            crc_d = crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= SEED;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/udma_din_sender.sv
module udma_din_sender
    import udma_pkg::*;
#(
    parameter int          CLK_PS   = 20000,
    parameter int          DW       = 16,
    parameter logic [15:0] CRC_SEED = 16'h4ABA
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode_i,
    input  logic          word_valid_i,
    input  logic [DW-1:0] word_i,
    output logic          word_take_o,
    output logic          req_o,
    input  logic          ack_n_i,
    input  logic          stop_i,
    input  logic          host_rdy_n_i,
    output logic          strobe_o,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o
);
    localparam int MODE_TOP = 5;

    typedef struct packed {
        state_e        st;
        logic          req;
        logic          strobe;
        logic          oe;
        logic          pending;
        logic [DW-1:0] dd;
        tim_t          tim;
        logic [TW-1:0] prev_gap;
    } regs_t;

    regs_t r_d, r_q;

    logic [2:0]    mode_eff;
    tim_t          tim_tab;
    logic [TW-1:0] since_edge, data_age;
    logic          se_clr, se_fill, age_clr;
    logic          crc_init, crc_upd;
    logic [15:0]   crc_val;
    logic          take;

    assign mode_eff = (int'(mode_i) > MODE_TOP) ? 3'(MODE_TOP) : mode_i;

    udma_mode_timing #(.CLK_PS(CLK_PS)) i_timing (
        .mode_i (mode_eff),
        .tim_o  (tim_tab)
    );

    udma_sat_counter #(.W(TW)) i_edge_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (se_clr),
        .fill_i (se_fill),
        .cnt_o  (since_edge)
    );

    udma_sat_counter #(.W(TW)) i_age_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (age_clr),
        .fill_i (1'b0),
        .cnt_o  (data_age)
    );

    udma_crc16 #(.SEED(CRC_SEED)) i_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .init_i (crc_init),
        .upd_i  (crc_upd),
        .word_i (r_q.dd),
        .crc_o  (crc_val)
    );

    always_comb begin
        int se1, age1, pair;
        r_d      = r_q;
        se_clr   = 1'b0;
        se_fill  = 1'b0;
        age_clr  = 1'b0;
        crc_init = 1'b0;
        crc_upd  = 1'b0;
        take     = 1'b0;
        se1      = int'(since_edge) + 1;
        age1     = int'(data_age) + 1;
        pair     = int'(r_q.prev_gap) + se1;

        case (r_q.st)
            S_IDLE: begin
                r_d.strobe = 1'b1;
                r_d.oe     = 1'b0;
                r_d.req    = 1'b0;
                if (word_valid_i) begin
                    r_d.req = 1'b1;
                    r_d.tim = tim_tab;
                    r_d.st  = S_REQ;
                end
            end
            S_REQ: begin
                if (!ack_n_i) begin
                    se_clr = 1'b1;
                    r_d.st = S_ACK;
                end
            end
            S_ACK: begin
                if (se1 >= int'(r_q.tim.ack)) begin
                    r_d.oe       = 1'b1;
                    r_d.pending  = 1'b0;
                    r_d.prev_gap = '1;
                    se_fill      = 1'b1;
                    crc_init     = 1'b1;
                    r_d.st       = S_DRIVE;
                end
            end
            S_DRIVE: begin
                if (stop_i) begin
                    r_d.req = 1'b0;
                    r_d.st  = S_END;
                end else if (r_q.pending) begin
                    if (!host_rdy_n_i && age1 >= int'(r_q.tim.dvs) &&
                        se1 >= int'(r_q.tim.cyc) && pair >= int'(r_q.tim.cyc2)) begin
                        r_d.strobe   = ~r_q.strobe;
                        r_d.pending  = 1'b0;
                        r_d.prev_gap = (se1 > TMAX) ? TW'(TMAX) : TW'(se1);
                        crc_upd      = 1'b1;
                        se_clr       = 1'b1;
                    end
                end else if (se1 >= int'(r_q.tim.dvh)) begin
                    if (word_valid_i) begin
                        take        = 1'b1;
                        r_d.dd      = word_i;
                        r_d.pending = 1'b1;
                        age_clr     = 1'b1;
                    end else if (se1 >= int'(r_q.tim.ss)) begin
                        r_d.req = 1'b0;
                        r_d.st  = S_WSTOP;
                    end
                end
            end
            S_WSTOP: begin
                if (stop_i) r_d.st = S_END;
            end
            S_END: begin
                if (se1 >= int'(r_q.tim.cyc)) begin
                    r_d.strobe = 1'b1;
                    r_d.dd     = crc_val;
                    r_d.st     = S_CRC;
                end
            end
            S_CRC: begin
                if (ack_n_i) begin
                    r_d.oe = 1'b0;
                    r_d.st = S_IDLE;
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= S_IDLE;
            r_q.req      <= 1'b0;
            r_q.strobe   <= 1'b1;
            r_q.oe       <= 1'b0;
            r_q.pending  <= 1'b0;
            r_q.dd       <= '0;
            r_q.tim      <= '0;
            r_q.prev_gap <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign word_take_o = take;
    assign req_o       = r_q.req;
    assign strobe_o    = r_q.strobe;
    assign data_o      = r_q.dd;
    assign data_oe_o   = r_q.oe;

    // R1: strobe rests high whenever the bus is released
    p_strobe_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !data_oe_o |-> strobe_o);

    // R3: a word is taken only when offered and no word awaits its strobe
    p_take_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        word_take_o |-> (word_valid_i && !r_q.pending));

    // R6: host not ready during transfer freezes the strobe at the next edge
    p_pause_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DRIVE && host_rdy_n_i) |=> $stable(strobe_o));

    // R7: host stop drops the request and strobes nothing more at once
    p_host_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DRIVE && stop_i) |=> (!req_o && $stable(strobe_o)));

    // R9: CRC word stays on the bus while acknowledged
    p_crc_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_CRC && !ack_n_i) |=> ($stable(data_o) && data_oe_o));

    // R4: no strobe transition closer than the latched cycle limit
    p_edge_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_DRIVE && r_d.strobe != r_q.strobe) |-> (int'(since_edge) + 1 >= int'(r_q.tim.cyc)));
endmodule

// File: tb/test_udma_din_sender.sv
`timescale 1ns/1ps
module test_udma_din_sender;
    import udma_pkg::crc_step;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = 3'd0;
    logic        word_valid_i;
    logic [15:0] word_i;
    logic        word_take_o, req_o, strobe_o, data_oe_o;
    logic        ack_n_i = 1'b1, stop_i = 1'b0, host_rdy_n_i = 1'b0;
    logic [15:0] data_o;

    always #10 clk = ~clk;

    udma_din_sender i_udma_din_sender (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .word_valid_i(word_valid_i), .word_i(word_i), .word_take_o(word_take_o),
        .req_o(req_o), .ack_n_i(ack_n_i), .stop_i(stop_i), .host_rdy_n_i(host_rdy_n_i),
        .strobe_o(strobe_o), .data_o(data_o), .data_oe_o(data_oe_o)
    );

    // limits in tenths of a nanosecond, modes 0..5
    int t_cyc[6]  = '{1120, 730, 540, 390, 250, 168};
    int t_cyc2[6] = '{2300, 1530, 1150, 860, 570, 380};
    int t_dvs[6]  = '{700, 480, 310, 200, 67, 48};
    int t_dvh[6]  = '{62, 62, 62, 62, 62, 48};
    int t_fs[6]   = '{2300, 2000, 1700, 1300, 1200, 900};
    int t_rfs[6]  = '{750, 700, 600, 600, 600, 500};

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int m = 0;
    logic [15:0] src[64];
    logic [15:0] rx[64];
    int src_n = 0, src_idx = 0, nrx = 0;
    bit src_en = 0, capturing = 0, paused = 0;
    int ack_cyc, pause_cyc, last_edge, prev_edge, data_chg, fall_cyc, first_fs;
    bit have_edge, have_prev;
    int v_cyc, v_cyc2, v_dvs, v_dvh, v_pause, v_take;
    logic [15:0] crc_ref;
    logic strobe_prev = 1'b1, req_prev = 1'b0, take_prev = 1'b0;
    logic [15:0] dd_prev = '0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // host-side monitor and word source, all sampling on the falling edge
    always @(negedge clk) begin
        cyc++;
        if (data_oe_o && src_idx < src_n && data_o == src[src_idx] && data_o != dd_prev) begin
            if (!take_prev) v_take++;
            if (have_edge && (cyc - last_edge) * 200 < t_dvh[m]) v_dvh++;
            data_chg = cyc;
            src_idx++;
        end
        if (capturing && data_oe_o && strobe_o != strobe_prev) begin
            if (have_edge && (cyc - last_edge) * 200 < t_cyc[m]) v_cyc++;
            if (have_prev && (cyc - prev_edge) * 200 < t_cyc2[m]) v_cyc2++;
            if ((cyc - data_chg) * 200 < t_dvs[m]) v_dvs++;
            if (!have_edge) first_fs = (cyc - ack_cyc) * 200 - 110;
            if (paused && (cyc - pause_cyc) * 200 - 110 > t_rfs[m]) v_pause++;
            if (nrx < 64) rx[nrx] = data_o;
            nrx++;
            crc_ref = crc_step(crc_ref, data_o);
            prev_edge = last_edge;
            have_prev = have_edge;
            last_edge = cyc;
            have_edge = 1;
        end
        if (req_prev && !req_o) fall_cyc = cyc;
        req_prev    = req_o;
        strobe_prev = strobe_o;
        dd_prev     = data_o;
        take_prev   = word_take_o;
        word_valid_i = src_en && (src_idx < src_n);
        word_i       = src[src_idx < 64 ? src_idx : 63];
    end

    task automatic step;
        @(negedge clk); #1;
    endtask

    task automatic reset_check;
        rst_n = 1'b0;
        repeat (3) step();
        chk(req_o == 1'b0, "R1", "request after reset", int'(req_o), 0);
        chk(strobe_o == 1'b1, "R1", "strobe after reset", int'(strobe_o), 1);
        chk(data_oe_o == 1'b0, "R1", "bus enable after reset", int'(data_oe_o), 0);
        chk(word_take_o == 1'b0, "R1", "take after reset", int'(word_take_o), 0);
        rst_n = 1'b1;
        step();
    endtask

    // one burst: mode, word count, pause point (-1 none), host stop point (-1 none), change mode after ack
    task automatic run_burst(input int mode, input int nw, input int pause_at, input int stop_at, input bit remode);
        int guard, pc, exp_n;
        bit pause_done, sb;
        m = (mode > 5) ? 5 : mode;
        for (int k = 0; k < 64; k++) src[k] = 16'h1357 + 16'(k * 16'h0A31) ^ 16'(mode << 12);
        src_idx = 0; src_n = nw; nrx = 0; crc_ref = 16'h4ABA;
        v_cyc = 0; v_cyc2 = 0; v_dvs = 0; v_dvh = 0; v_pause = 0; v_take = 0;
        have_edge = 0; have_prev = 0; data_chg = 0; first_fs = 0; pause_done = 0; sb = 0;
        mode_i = 3'(mode);
        src_en = 1;
        guard = 0;
        while (!req_o && guard < 50) begin step(); guard++; end
        chk(req_o == 1'b1, "R2", "request raised", int'(req_o), 1);
        repeat (4) begin
            step();
            if (data_oe_o || !strobe_o) sb = 1;
        end
        chk(!sb, "R2", "quiet before acknowledge", int'(sb), 0);
        ack_n_i = 1'b0; ack_cyc = cyc; capturing = 1;
        if (remode) mode_i = 3'd5;
        guard = 0; pc = 0;
        while (guard < 3000) begin
            step(); guard++;
            if (pause_at >= 0 && !pause_done && !paused && nrx >= pause_at) begin
                host_rdy_n_i = 1'b1; paused = 1; pause_cyc = cyc; pc = 0;
            end else if (paused) begin
                pc++;
                if (pc == 15) begin
                    chk(nrx <= pause_at + 1, "R6", "words during pause", nrx, pause_at + 1);
                    host_rdy_n_i = 1'b0; paused = 0; pause_done = 1;
                end
            end
            if (stop_at >= 0 && nrx >= stop_at) break;
            if (!req_o) break;
        end
        exp_n = (stop_at >= 0) ? stop_at : nw;
        if (stop_at < 0) begin
            chk(req_o == 1'b0, "R8", "device dropped request", int'(req_o), 0);
            chk((fall_cyc - last_edge) * 200 >= 500, "R8", "last edge to request drop x0.1ns",
                (fall_cyc - last_edge) * 200, 500);
        end
        stop_i = 1'b1; capturing = 0; src_en = 0;
        step();
        if (stop_at >= 0) chk(req_o == 1'b0, "R7", "request after host stop", int'(req_o), 0);
        repeat (14) step();
        chk(nrx == exp_n, "R3", "words strobed", nrx, exp_n);
        for (int k = 0; k < exp_n && k < 64; k++)
            if (rx[k] != src[k]) chk(0, "R3", $sformatf("word %0d", k), int'(rx[k]), int'(src[k]));
        chk(v_take == 0, "R3", "bus updates without take", v_take, 0);
        chk(v_cyc == 0, "R4", "edge spacing violations", v_cyc, 0);
        chk(v_cyc2 == 0, "R4", "same polarity spacing violations", v_cyc2, 0);
        chk(v_dvs == 0, "R5", "setup violations", v_dvs, 0);
        chk(v_dvh == 0, "R5", "hold violations", v_dvh, 0);
        chk(first_fs <= t_fs[m], "R2", "first strobe delay x0.1ns", first_fs, t_fs[m]);
        if (pause_at >= 0) chk(v_pause == 0, "R6", "edges past pause window", v_pause, 0);
        chk(strobe_o == 1'b1, "R9", "strobe returned high", int'(strobe_o), 1);
        chk(data_oe_o == 1'b1, "R9", "bus driven with CRC", int'(data_oe_o), 1);
        chk(data_o == crc_ref, "R9", "CRC word", int'(data_o), int'(crc_ref));
        ack_n_i = 1'b1; stop_i = 1'b0;
        repeat (2) step();
        chk(data_oe_o == 1'b0 && req_o == 1'b0, "R9", "idle after acknowledge release",
            int'({req_o, data_oe_o}), 0);
        mode_i = 3'd0;
    endtask

    initial begin
        word_valid_i = 1'b0;
        word_i = '0;
        reset_check();
        run_burst(0, 12, -1, -1, 1'b1);   // R10: mode change after request ignored
        run_burst(7, 20, -1, -1, 1'b0);   // R10: mode 7 acts as mode 5
        run_burst(2, 16, 5, -1, 1'b0);    // R6 pause
        run_burst(3, 30, -1, 7, 1'b0);    // R7 host stop
        run_burst(4, 9, 3, -1, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule